// File: doc/BRIEF.md
# Calendar Time Counter

This block keeps wall-clock time and calendar date in hardware. A one-cycle strobe arriving once per second advances a chain of counters for seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each carry runs into the next counter. Day-of-month rollover follows the length of the current month, and February gets a leap day in years divisible by four.

Two control inputs set how the values appear at the outputs and how write data is read. One selects packed BCD or plain binary. The other selects 24-hour or 12-hour presentation, and in 12-hour mode the top bit of the hour byte marks afternoon. Time is held internally in one canonical binary form, so a change on either control input reformats the outputs at once. Software can load any single field through a write port. Around each advance the block raises a busy flag while the time may be in flux, and it pulses a completion strobe when the new time is in place.

Top module: `calendar_counter`

## Requirements
- R1: Seconds and minutes count 0 to 59. A seconds wrap carries into minutes, and a minutes wrap carries into hours.
- R2: With `cfg_24h`=1, hours count 0 to 23. Wrapping from 23 to 0 carries into the date.
- R3: With `cfg_24h`=0, the hour output's low seven bits show 1 to 12 and bit 7 is 1 for PM. The sequence is 11 AM to 12 PM to 1 PM, and 11 PM to 12 AM. Binary 12 AM is 0x0C, and binary 12 PM is 0x8C.
- R4: Day of week counts 1 to 7 and steps from 7 back to 1 on each date carry.
- R5: Day of month wraps to 1 after the month's last day. April, June, September and November have 30 days. February has 29 days when the year is a multiple of 4 and 28 days otherwise. All other months have 31 days.
- R6: Month counts 1 to 12, and its wrap increments the year. The year counts 0 to 99 and wraps to 0.
- R7: `cfg_binary`=0 shows every field as two packed BCD digits. `cfg_binary`=1 shows plain binary. A change of either control input changes the outputs combinationally.
- R8: When `wr_en`=1, the next clock edge loads the field chosen by `wr_sel` (0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year). `wr_data` is read in the current format, with bit 7 as PM for hours in 12-hour mode. `wr_sel`=7 changes nothing. A write on the same edge as an advance wins for the field it writes.
- R9: `busy` rises on the edge after a sampled `tick` and stays high for two cycles. The time fields change on the edge where `busy` falls, and at no other time except through writes.
- R10: `done` is high for exactly one cycle, starting on the edge where the time advances.
- R11: A `tick` that arrives while `busy` is high is ignored.
- R12: Reset is synchronous and active high. It gives 00:00:00, day of week 1, date 1, month 1, year 0, with `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle once-per-second advance strobe |
| cfg_binary | input | 1 | 1 = binary, 0 = BCD |
| cfg_24h | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| wr_en | input | 1 | Field write enable |
| wr_sel | input | 3 | Field selector |
| wr_data | input | 8 | Field value in the current format |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |
| busy | output | 1 | Update in progress |
| done | output | 1 | Update-finished strobe |

## Verification
The bench drives the chain across its worst carries and leap cases:
- **Full cascade:** Dec 31, year 99, 23:59:59 must roll every field at once. A broken carry leaves one field stale.
- **February:** it is taken through both a leap year and a common year. A wrong month-length table shows up as Feb 29 in year 23 or as Mar 1 straight after Feb 28 in year 24.
- **12-hour mode:** the noon and midnight crossings are checked. An off-by-twelve mapping shows 0 or 13, or flips the PM bit at the wrong hour.
- **Timing races:** a second tick arrives during the busy window, and a write lands on the advance edge. A design that re-arms would count twice, and one that lets the advance override the write would lose the loaded value.

// File: rtl/calendar_pkg.sv
package calendar_pkg;

    localparam int FW       = 7;          // width of one stored field
    localparam int NFIELD   = 7;          // sec, min, hour, dow, date, month, year
    localparam int TW       = FW * NFIELD;
    localparam int IDX_HOUR = 2;

    localparam logic [FW-1:0] SEC_LAST  = 7'd59;
    localparam logic [FW-1:0] HOUR_LAST = 7'd23;
    localparam logic [FW-1:0] DOW_LAST  = 7'd7;
    localparam logic [FW-1:0] MON_LAST  = 7'd12;
    localparam logic [FW-1:0] YEAR_LAST = 7'd99;

    // declared high field first so sec occupies the low bits
    typedef struct packed {
        logic [FW-1:0] year;
        logic [FW-1:0] mon;
        logic [FW-1:0] date;
        logic [FW-1:0] dow;
        logic [FW-1:0] hour;
        logic [FW-1:0] min;
        logic [FW-1:0] sec;
    } caltime_t;

    typedef enum logic [1:0] {PH_IDLE, PH_ARM, PH_STEP} phase_e;

    localparam caltime_t RESET_TIME = '{year: 7'd0, mon: 7'd1, date: 7'd1,
                                        dow: 7'd1, hour: 7'd0, min: 7'd0, sec: 7'd0};

    function automatic logic [7:0] to_bcd(input logic [FW-1:0] v);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(v / 7'd10);
        ones = 4'(v - 7'(tens) * 7'd10);
        return {tens, ones};
    endfunction

    function automatic logic [FW-1:0] from_bcd(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [FW-1:0] month_days(input logic [FW-1:0] mon,
                                                 input logic [FW-1:0] year);
        case (mon)
            7'd2:                     return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
            default:                  return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_phase_ctrl.sv
module cal_phase_ctrl
    import calendar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic step,
    output logic busy,
    output logic done
);

    phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
            done <= 1'b0;
        end else begin
            done <= (ph_q == PH_STEP);
            case (ph_q)
                PH_IDLE: if (tick) ph_q <= PH_ARM;
                PH_ARM:  ph_q <= PH_STEP;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign busy = (ph_q != PH_IDLE);
    assign step = (ph_q == PH_STEP);

endmodule

// File: rtl/cal_advance.sv
module cal_advance
    import calendar_pkg::*;
(
    input  caltime_t cur,
    output caltime_t nxt
);

    always_comb begin
        nxt = cur;
        if (cur.sec < SEC_LAST) begin
            nxt.sec = cur.sec + 7'd1;
        end else begin
            nxt.sec = '0;
            if (cur.min < SEC_LAST) begin
                nxt.min = cur.min + 7'd1;
            end else begin
                nxt.min = '0;
                if (cur.hour < HOUR_LAST) begin
                    nxt.hour = cur.hour + 7'd1;
                end else begin
                    nxt.hour = '0;
                    nxt.dow  = (cur.dow >= DOW_LAST || cur.dow == '0) ? 7'd1 : cur.dow + 7'd1;
                    if (cur.date < month_days(cur.mon, cur.year)) begin
                        nxt.date = cur.date + 7'd1;
                    end else begin
                        nxt.date = 7'd1;
                        if (cur.mon < MON_LAST) begin
                            nxt.mon = cur.mon + 7'd1;
                        end else begin
                            nxt.mon  = 7'd1;
                            nxt.year = (cur.year < YEAR_LAST) ? cur.year + 7'd1 : '0;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cal_field_fmt.sv
module cal_field_fmt
    import calendar_pkg::*;
#(
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [FW-1:0] val,
    input  logic          cfg_binary,
    input  logic          cfg_24h,
    output logic [7:0]    code
);

    logic [FW-1:0] hr12;

    always_comb begin
        if (val == '0)          hr12 = 7'd12;
        else if (val > 7'd12)   hr12 = val - 7'd12;
        else                    hr12 = val;

        if (IS_HOUR && !cfg_24h) begin
            code = (cfg_binary ? {1'b0, hr12} : to_bcd(hr12))
                 | {(val >= 7'd12), 7'b0};
        end else begin
            code = cfg_binary ? {1'b0, val} : to_bcd(val);
        end
    end

endmodule

// File: rtl/calendar_counter.sv
module calendar_counter
    import calendar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cfg_binary,
    input  logic       cfg_24h,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       busy,
    output logic       done
);

    logic [TW-1:0] cur_q;
    logic [TW-1:0] nxt;
    caltime_t      cur_s;
    caltime_t      adv_s;
    logic          step;
    logic [FW-1:0] wval;
    logic [FW-1:0] full_v;
    logic [FW-1:0] body_v;
    logic [7:0]    code [NFIELD];

    cal_phase_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .step (step),
        .busy (busy),
        .done (done)
    );

    assign cur_s = caltime_t'(cur_q);

    cal_advance u_adv (
        .cur (cur_s),
        .nxt (adv_s)
    );

    // interpret write data in the format currently selected
    always_comb begin
        full_v = cfg_binary ? wr_data[6:0] : from_bcd(wr_data);
        body_v = cfg_binary ? wr_data[6:0] : from_bcd({1'b0, wr_data[6:0]});
        if (wr_sel == 3'(IDX_HOUR) && !cfg_24h)
            wval = ((body_v == 7'd12) ? 7'd0 : body_v) + (wr_data[7] ? 7'd12 : 7'd0);
        else
            wval = full_v;
    end

    always_comb begin
        nxt = step ? TW'(adv_s) : cur_q;
        if (wr_en && wr_sel < 3'(NFIELD))
            nxt[wr_sel * FW +: FW] = wval;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= TW'(RESET_TIME);
        else     cur_q <= nxt;
    end

    for (genvar i = 0; i < NFIELD; i++) begin : g_fmt
        cal_field_fmt #(.IS_HOUR((i == IDX_HOUR) ? 1'b1 : 1'b0)) u_fmt (
            .val        (cur_q[i*FW +: FW]),
            .cfg_binary (cfg_binary),
            .cfg_24h    (cfg_24h),
            .code       (code[i])
        );
    end

    assign sec_o   = code[0];
    assign min_o   = code[1];
    assign hour_o  = code[2];
    assign dow_o   = code[3];
    assign date_o  = code[4];
    assign month_o = code[5];
    assign year_o  = code[6];

endmodule

// File: rtl/calendar_counter_chk.sv
module calendar_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       cfg_binary,
    input logic       cfg_24h,
    input logic       wr_en,
    input logic [7:0] sec_o,
    input logic [7:0] hour_o,
    input logic [7:0] dow_o,
    input logic       busy,
    input logic       done
);

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        cfg_binary |-> sec_o < 8'd60);                                   // R1

    AST_HOUR24_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cfg_binary && cfg_24h) |-> hour_o < 8'd24);                     // R2

    AST_HOUR12_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cfg_binary && !cfg_24h) |-> (hour_o[6:0] >= 7'd1 && hour_o[6:0] <= 7'd12)); // R3

    AST_DOW_RANGE: assert property (@(posedge clk) disable iff (rst)
        cfg_binary |-> (dow_o >= 8'd1 && dow_o <= 8'd7));                // R4

    AST_BUSY_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tick));                                    // R9

    AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy);                                // R9

    AST_TIME_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(wr_en) && $stable(cfg_binary)) |-> $stable(sec_o)); // R9

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);                                           // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                 // R10

endmodule

bind calendar_counter calendar_counter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .cfg_binary (cfg_binary),
    .cfg_24h    (cfg_24h),
    .wr_en      (wr_en),
    .sec_o      (sec_o),
    .hour_o     (hour_o),
    .dow_o      (dow_o),
    .busy       (busy),
    .done       (done)
);

// File: tb/sim_calendar_counter.sv
module sim_calendar_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       cfg_binary = 1'b0;
    logic       cfg_24h = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
    logic       busy, done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // reference model state: 0 sec,1 min,2 hour,3 dow,4 date,5 month,6 year
    int mt [7];
    int pend = 0;
    bit mdone = 1'b0;
    int wint = 0;

    always #5 clk = ~clk;   // 100 MHz

    calendar_counter u0 (
        .clk(clk), .rst(rst), .tick(tick), .cfg_binary(cfg_binary), .cfg_24h(cfg_24h),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o),
        .busy(busy), .done(done)
    );

    function automatic int mlen(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int enc(int v, bit bin);
        return bin ? v : ((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int enc_hour(int h, bit bin, bit h24);
        int h12;
        if (h24) return enc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return enc(h12, bin) + ((h >= 12) ? 128 : 0);
    endfunction

    task automatic model_advance();
        mt[0]++;
        if (mt[0] == 60) begin
            mt[0] = 0; mt[1]++;
            if (mt[1] == 60) begin
                mt[1] = 0; mt[2]++;
                if (mt[2] == 24) begin
                    mt[2] = 0;
                    mt[3] = (mt[3] == 7) ? 1 : mt[3] + 1;
                    if (mt[4] == mlen(mt[5], mt[6])) begin
                        mt[4] = 1;
                        if (mt[5] == 12) begin
                            mt[5] = 1;
                            mt[6] = (mt[6] == 99) ? 0 : mt[6] + 1;
                        end else mt[5]++;
                    end else mt[4]++;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            mt = '{0, 0, 0, 1, 1, 1, 0};
            pend = 0;
            mdone = 1'b0;
        end else begin
            mdone = 1'b0;
            if (pend == 2) begin
                model_advance();
                mdone = 1'b1;
                pend = 0;
            end else if (pend == 1) pend = 2;
            else if (tick) pend = 1;
            if (wr_en && wr_sel < 3'd7) mt[wr_sel] = wint;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always @(posedge clk) begin
        #2;
        if (!rst && !finished) begin
            chk("R1", "sec", int'(sec_o), enc(mt[0], cfg_binary));
            chk("R1", "min", int'(min_o), enc(mt[1], cfg_binary));
            chk(cfg_24h ? "R2" : "R3", "hour", int'(hour_o), enc_hour(mt[2], cfg_binary, cfg_24h));
            chk("R4", "dow", int'(dow_o), enc(mt[3], cfg_binary));
            chk("R5", "date", int'(date_o), enc(mt[4], cfg_binary));
            chk("R6", "month", int'(month_o), enc(mt[5], cfg_binary));
            chk("R6", "year", int'(year_o), enc(mt[6], cfg_binary));
            chk("R9", "busy", int'(busy), (pend != 0) ? 1 : 0);
            chk("R10", "done", int'(done), int'(mdone));
        end
    end

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(int sel, int v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wint = v;
        wr_data = (sel == 2) ? 8'(enc_hour(v, cfg_binary, cfg_24h)) : 8'(enc(v, cfg_binary));
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wr_h12(int h12, bit pm);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd2;
        wint = (h12 % 12) + (pm ? 12 : 0);
        wr_data = 8'(enc(h12, cfg_binary) + (pm ? 128 : 0));
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_time(int yr, int mo, int dt, int dw, int hr, int mi, int se);
        wr(6, yr); wr(5, mo); wr(4, dt); wr(3, dw); wr(2, hr); wr(1, mi); wr(0, se);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12", "sec", int'(sec_o), 0);
        chk("R12", "hour", int'(hour_o), 0);
        chk("R12", "dow", int'(dow_o), 1);
        chk("R12", "busy", int'(busy), 0);

        // R1 plain counting across a minute
        for (int i = 0; i < 62; i++) do_tick();
        chk("R1", "sec after 62", int'(sec_o), 'h02);
        chk("R1", "min after 62", int'(min_o), 'h01);

        // R2 R4 R6 full cascade at year end
        set_time(99, 12, 31, 7, 23, 59, 59);
        do_tick();
        chk("R6", "year wrap", int'(year_o), 'h00);
        chk("R4", "dow wrap", int'(dow_o), 'h01);
        chk("R2", "hour wrap", int'(hour_o), 'h00);

        // R5 February common and leap, 30-day month
        set_time(23, 2, 28, 3, 23, 59, 59);
        do_tick();
        chk("R5", "common feb", int'(month_o), 'h03);
        set_time(24, 2, 28, 3, 23, 59, 59);
        do_tick();
        chk("R5", "leap day", int'(date_o), 'h29);
        wr(2, 23); wr(1, 59); wr(0, 59);
        do_tick();
        chk("R5", "after leap day", int'(date_o), 'h01);
        set_time(5, 4, 30, 2, 23, 59, 59);
        do_tick();
        chk("R5", "april end", int'(month_o), 'h05);

        // R3 12-hour binary crossings
        @(negedge clk); cfg_binary = 1'b1; cfg_24h = 1'b0;
        wr_h12(11, 1'b0); wr(1, 59); wr(0, 59);
        do_tick();
        chk("R3", "noon", int'(hour_o), 'h8C);
        wr_h12(12, 1'b1); wr(1, 59); wr(0, 59);
        do_tick();
        chk("R3", "one pm", int'(hour_o), 'h81);
        wr_h12(11, 1'b1); wr(1, 59); wr(0, 59);
        do_tick();
        chk("R3", "midnight", int'(hour_o), 'h0C);
        // R7 switch to BCD presentation
        @(negedge clk); cfg_binary = 1'b0;
        @(negedge clk);
        chk("R7", "bcd midnight", int'(hour_o), 'h12);
        @(negedge clk); cfg_24h = 1'b1;
        wr(0, 45);
        chk("R7", "bcd sec", int'(sec_o), 'h45);
        @(negedge clk); cfg_binary = 1'b1;
        @(negedge clk);
        chk("R7", "bin sec", int'(sec_o), 'h2D);

        // R11 tick during busy ignored
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11", "single step", int'(sec_o), 46);

        // R8 write landing on the advance edge wins; selector 7 ignored
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wint = 10; wr_data = 8'd10;
        @(negedge clk); wr_en = 1'b0;
        chk("R8", "write wins", int'(sec_o), 10);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd7; wint = 0; wr_data = 8'd33;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        chk("R8", "sel 7 ignored", int'(sec_o), 10);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule